// File: doc/BRIEF.md
# Page Storage-Key Reference/Change Updater

This block keeps the per-page storage key up to date each time a new address translation is installed. A requester presents an absolute byte address, an access kind (load, store or instruction fetch) and the permission set that the translation would grant. The block reads the 7-bit key of the 4 KiB page that holds the address from an external key RAM. It sets the reference bit, and also the change bit on a store, then writes the key back. It returns the permission set, adjusted for the key.

On a load or a fetch to a page whose change bit is still clear, write permission is taken out of the returned set. The first later store therefore has to come back through this block, and that store records the change. An address at or above the installed memory size skips the key RAM entirely. A key read that reports an error also suppresses the write-back. The reference and change bits may be set even if the access that caused the update faults later. An unsupported access-kind code is flagged and causes no key traffic.

Top module: `skey_rc_updater`

## Requirements
- R1: After reset `busy`, `done`, `rsp_bad`, `key_rd_en` and `key_wr_en` are all low.
- R2: The key RAM is addressed with the page number, which is the absolute address shifted right by 12 (4 KiB pages).
- R3: An address at or above `MEM_BYTES` causes no key read or write. `done` rises in the cycle after acceptance, and `rsp_perm` equals `req_perm`.
- R4: On a load (`req_kind`=00) or a fetch (`req_kind`=10) whose stored key has the change bit (key bit 0) clear, the returned permissions have the write bit (perm bit 1) cleared. The read bit (perm bit 0) and the execute bit (perm bit 2) are kept.
- R5: On a load or a fetch whose key has the change bit set, `rsp_perm` equals `req_perm`.
- R6: On a store (`req_kind`=01) the written key has the change bit set, and `rsp_perm` equals `req_perm`.
- R7: Every handled access writes back the key with the reference bit (key bit 1) set. Key bits 6..2 are kept unchanged.
- R8: If `key_rd_err` is high with the read data, no write-back occurs, `rsp_perm` equals `req_perm`, and `done` comes three cycles after acceptance.
- R9: `req_kind`=11 sets `rsp_bad` with `done` in the cycle after acceptance. It causes no key access, and `rsp_perm` equals `req_perm`.
- R10: A handled access puts `key_rd_en` high for exactly the cycle after acceptance, puts `key_wr_en` high two cycles after the read, and raises `done` in the cycle after the write.
- R11: `busy` is high from the cycle after acceptance through the `done` cycle. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_addr | input | AW | Absolute byte address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 unsupported |
| req_perm | input | 3 | Incoming permissions: bit0 read, bit1 write, bit2 execute |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle response strobe |
| rsp_perm | output | 3 | Adjusted permissions, valid with `done` |
| rsp_bad | output | 1 | Unsupported access kind, valid with `done` |
| key_rd_en | output | 1 | Key RAM read strobe |
| key_addr | output | AW-12 | Key RAM page index |
| key_rd_data | input | 7 | Key read data, valid the cycle after `key_rd_en` |
| key_rd_err | input | 1 | Key read error, valid with `key_rd_data` |
| key_wr_en | output | 1 | Key RAM write strobe |
| key_wr_data | output | 7 | Updated key: bit0 change, bit1 reference, bits 6..2 kept |

## Verification
On every cycle the assertions check the shape of the key-RAM handshake: a single read strobe, a write exactly two cycles after a read, no write following an erroring read, and no key access for an unsupported kind. They also check that each written key carries the reference bit, and the change bit after a store. Only the bench's scenarios can show the values that result. Those are the removal of write permission depending on the stored change bit, the pass-through above installed memory and at its last page, the preservation of the other key bits, and a request ignored while busy leaving its target page untouched.

// File: rtl/skey_pkg.sv
package skey_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_CHECK,
      ST_WRITE,
      ST_DONE
   } upd_state_e;

   localparam int PERM_W      = 3;
   localparam int PERM_WR_BIT = 1;
   localparam int KEY_CHG_BIT = 0;
   localparam int KEY_REF_BIT = 1;
endpackage

// File: rtl/skey_page_index.sv
module skey_page_index #(
   parameter int          AW         = 32,
   parameter int          PAGE_SHIFT = 12,
   parameter logic [63:0] MEM_BYTES  = 64'h0010_0000
) (
   input  logic [AW-1:0]            addr,
   output logic [AW-PAGE_SHIFT-1:0] page,
   output logic                     in_range
);
   localparam logic [63:0] SPACE = 64'd1 << AW;

   if (AW > 63 || AW <= PAGE_SHIFT) begin : g_bad_aw
      $error("skey_page_index: AW must exceed PAGE_SHIFT and stay below 64");
   end

   assign page = addr[AW-1:PAGE_SHIFT];

   if (MEM_BYTES >= SPACE) begin : g_full_space
      assign in_range = 1'b1;
   end else begin : g_limited
      assign in_range = ({{(64-AW){1'b0}}, addr} < MEM_BYTES);
   end
endmodule

// File: rtl/skey_key_merge.sv
module skey_key_merge
   import skey_pkg::*;
#(
   parameter int KEY_W = 7
) (
   input  acc_kind_e         kind,
   input  logic [KEY_W-1:0]  key_in,
   input  logic [PERM_W-1:0] perm_in,
   output logic [KEY_W-1:0]  key_out,
   output logic [PERM_W-1:0] perm_out
);
   if (KEY_W < 2) begin : g_bad_key
      $error("skey_key_merge: key needs room for reference and change bits");
   end

   logic is_store;
   logic read_type;

   assign is_store  = (kind == ACC_STORE);
   assign read_type = (kind == ACC_LOAD) || (kind == ACC_FETCH);

   always_comb begin
      key_out = key_in;
      key_out[KEY_REF_BIT] = 1'b1;
      if (is_store) key_out[KEY_CHG_BIT] = 1'b1;
      perm_out = perm_in;
      if (read_type && !key_in[KEY_CHG_BIT]) perm_out[PERM_WR_BIT] = 1'b0;
   end
endmodule

// File: rtl/skey_rc_updater.sv
module skey_rc_updater
   import skey_pkg::*;
#(
   parameter int          AW         = 32,
   parameter int          PAGE_SHIFT = 12,
   parameter int          KEY_W      = 7,
   parameter logic [63:0] MEM_BYTES  = 64'h0010_0000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [AW-1:0]            req_addr,
   input  logic [1:0]               req_kind,
   input  logic [2:0]               req_perm,
   output logic                     busy,
   output logic                     done,
   output logic [2:0]               rsp_perm,
   output logic                     rsp_bad,
   output logic                     key_rd_en,
   output logic [AW-PAGE_SHIFT-1:0] key_addr,
   input  logic [KEY_W-1:0]         key_rd_data,
   input  logic                     key_rd_err,
   output logic                     key_wr_en,
   output logic [KEY_W-1:0]         key_wr_data
);
   localparam int PW = AW - PAGE_SHIFT;

   if (PERM_W != 3) begin : g_bad_perm
      $error("skey_rc_updater: permission width must be 3");
   end

   upd_state_e        st_q;
   acc_kind_e         kind_q;
   logic [PW-1:0]     page_q;
   logic [2:0]        perm_q;
   logic [KEY_W-1:0]  key_q;
   logic [2:0]        rsp_perm_q;
   logic              rsp_bad_q;

   logic [PW-1:0]     req_page;
   logic              req_in_range;
   logic [KEY_W-1:0]  merged_key;
   logic [2:0]        merged_perm;
   logic              accept;

   skey_page_index #(
      .AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .MEM_BYTES(MEM_BYTES)
   ) u_index (
      .addr(req_addr), .page(req_page), .in_range(req_in_range)
   );

   skey_key_merge #(.KEY_W(KEY_W)) u_merge (
      .kind(kind_q), .key_in(key_rd_data), .perm_in(perm_q),
      .key_out(merged_key), .perm_out(merged_perm)
   );

   assign accept = req_valid && (st_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         kind_q     <= ACC_LOAD;
         page_q     <= '0;
         perm_q     <= '0;
         key_q      <= '0;
         rsp_perm_q <= '0;
         rsp_bad_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept) begin
               kind_q <= acc_kind_e'(req_kind);
               page_q <= req_page;
               perm_q <= req_perm;
               rsp_perm_q <= req_perm;
               rsp_bad_q  <= (acc_kind_e'(req_kind) == ACC_RSVD);
               if (acc_kind_e'(req_kind) == ACC_RSVD || !req_in_range)
                  st_q <= ST_DONE;
               else
                  st_q <= ST_READ;
            end
            ST_READ:  st_q <= ST_CHECK;
            ST_CHECK: begin
               if (key_rd_err) begin
                  st_q <= ST_DONE;
               end else begin
                  key_q      <= merged_key;
                  rsp_perm_q <= merged_perm;
                  st_q       <= ST_WRITE;
               end
            end
            ST_WRITE: st_q <= ST_DONE;
            ST_DONE:  st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (st_q != ST_IDLE);
   assign done        = (st_q == ST_DONE);
   assign rsp_perm    = rsp_perm_q;
   assign rsp_bad     = rsp_bad_q && done;
   assign key_rd_en   = (st_q == ST_READ);
   assign key_addr    = page_q;
   assign key_wr_en   = (st_q == ST_WRITE);
   assign key_wr_data = key_q;

   // R10: a write strobe always trails a read strobe by two cycles
   a_r10_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr_en |-> $past(key_rd_en, 2));

   // R10: the read strobe lasts a single cycle
   a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      key_rd_en |=> !key_rd_en);

   // R7: every written key carries the reference bit
   a_r7_ref_written: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr_en |-> key_wr_data[KEY_REF_BIT]);

   // R6: a store writes the change bit
   a_r6_store_change: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr_en && kind_q == ACC_STORE) |-> key_wr_data[KEY_CHG_BIT]);

   // R8: a read error suppresses the write-back
   a_r8_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (key_rd_err && $past(key_rd_en)) |=> !key_wr_en);

   // R9: an unsupported kind never touches the key RAM
   a_r9_bad_no_key: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_bad |-> (!$past(key_rd_en) && !key_wr_en));

   // R11: done is always inside the busy window
   a_r11_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
endmodule

// File: tb/skey_rc_updater_tb_top.sv
module skey_rc_updater_tb_top;
   localparam int          AW    = 32;
   localparam int          PW    = AW - 12;
   localparam int          NPG   = 256;
   localparam logic [63:0] MEMB  = 64'h0010_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_kind = '0;
   logic [2:0]    req_perm = '0;
   logic          busy, done, rsp_bad, key_rd_en, key_wr_en;
   logic [2:0]    rsp_perm;
   logic [PW-1:0] key_addr;
   logic [6:0]    key_rd_data, key_wr_data;
   logic          key_rd_err;

   logic [6:0]    ram [NPG];
   logic [6:0]    ekey [NPG];
   logic [3:0]    exp_q [$];
   int            checks = 0;
   int            fails = 0;
   localparam int ERR_PAGE = 9;

   always #5 clk = ~clk;

   function automatic logic [6:0] init_key(int i);
      return 7'({i[4:0], i[1:0]});
   endfunction

   skey_rc_updater #(.AW(AW), .MEM_BYTES(MEMB)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_kind(req_kind), .req_perm(req_perm), .busy(busy), .done(done),
      .rsp_perm(rsp_perm), .rsp_bad(rsp_bad), .key_rd_en(key_rd_en),
      .key_addr(key_addr), .key_rd_data(key_rd_data), .key_rd_err(key_rd_err),
      .key_wr_en(key_wr_en), .key_wr_data(key_wr_data)
   );

   // key RAM model: one-cycle read latency, one page flagged as erroring
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NPG; i++) ram[i] <= init_key(i);
         key_rd_data <= '0;
         key_rd_err  <= 1'b0;
      end else begin
         if (key_rd_en) begin
            key_rd_data <= ram[key_addr[7:0]];
            key_rd_err  <= (key_addr == PW'(ERR_PAGE));
         end
         if (key_wr_en) ram[key_addr[7:0]] <= key_wr_data;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every response strobe
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check(0, "R11", "unexpected response", 1, 0);
         end else begin
            logic [3:0] e;
            e = exp_q.pop_front();
            check({rsp_bad, rsp_perm} == e, "R4/R5/R6/R9", "response", {rsp_bad, rsp_perm}, e);
         end
      end
   end

   task automatic send(input logic [AW-1:0] a, input logic [1:0] k,
                       input logic [2:0] p, input bit poke, input string tag);
      bit         bad, handled, err, wr_seen;
      logic [2:0] ep;
      int         pg, n, exp_n;
      logic [6:0] k3;
      bad     = (k == 2'b11);
      handled = !bad && ({32'b0, a} < MEMB);
      pg      = int'(a >> 12);
      err     = handled && (pg == ERR_PAGE);
      ep      = p;
      if (handled && !err) begin
         if (k != 2'b01 && !ekey[pg][0]) ep[1] = 1'b0;
         ekey[pg][1] = 1'b1;
         if (k == 2'b01) ekey[pg][0] = 1'b1;
      end
      exp_n = !handled ? 1 : (err ? 3 : 4);
      exp_q.push_back({bad, ep});
      k3 = ram[3];
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_kind = k; req_perm = p;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 1; wr_seen = 0;
      while (!done && n < 12) begin
         if (n == 1) begin
            check(key_rd_en == handled, "R10", {tag, " read strobe"}, key_rd_en, handled);
            check(busy, "R11", {tag, " busy"}, busy, 1);
            if (key_rd_en) check(key_addr == PW'(pg), "R2", {tag, " page"}, key_addr, pg);
            if (poke) begin
               req_valid = 1'b1; req_addr = 32'h0000_3000; req_kind = 2'b01; req_perm = 3'b111;
            end
         end
         if (n == 2) req_valid = 1'b0;
         if (key_wr_en) wr_seen = 1;
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      check(n == exp_n, err ? "R8" : (handled ? "R10" : (bad ? "R9" : "R3")),
            {tag, " latency"}, n, exp_n);
      check(wr_seen == (handled && !err), err ? "R8" : "R3",
            {tag, " write-back"}, wr_seen, handled && !err);
      @(negedge clk);
      check(!done && !busy, "R11", {tag, " idle after"}, {done, busy}, 0);
      if (handled) check(ram[pg] == ekey[pg], "R7", {tag, " key"}, ram[pg], ekey[pg]);
      if (poke) check(ram[3] == k3, "R11", "ignored request page", ram[3], k3);
   endtask

   initial begin
      for (int i = 0; i < NPG; i++) ekey[i] = init_key(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!busy && !done && !rsp_bad && !key_rd_en && !key_wr_en, "R1", "reset outputs",
            {busy, done, rsp_bad, key_rd_en, key_wr_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      send(32'h0000_4010, 2'b00, 3'b111, 0, "R4 load clean");
      send(32'h0000_5ff8, 2'b00, 3'b111, 0, "R5 load changed");
      send(32'h0000_6000, 2'b10, 3'b111, 0, "R4 fetch clean");
      send(32'h0000_7abc, 2'b10, 3'b101, 0, "R5 fetch changed");
      send(32'h0000_4000, 2'b01, 3'b111, 0, "R6 store");
      send(32'h0000_4800, 2'b00, 3'b111, 0, "R5 load after store");
      send(32'h0000_8004, 2'b01, 3'b011, 0, "R6 store ro");
      send(32'h0000_a000, 2'b00, 3'b101, 0, "R4 load no write");
      send(32'h0000_1f00, 2'b10, 3'b110, 0, "R7 fetch odd key");
      send(32'h000f_ffff, 2'b00, 3'b111, 0, "R3 last page");
      send(32'h0010_0000, 2'b01, 3'b111, 0, "R3 at limit");
      send(32'h8000_0000, 2'b00, 3'b010, 0, "R3 far");
      send(32'h0000_9000, 2'b00, 3'b111, 0, "R8 read error");
      send(32'h0000_2000, 2'b11, 3'b101, 0, "R9 unsupported");
      send(32'h0000_c000, 2'b00, 3'b111, 1, "R11 poke busy");
      check(exp_q.size() == 0, "R11", "scoreboard drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule